// File: doc/BRIEF.md
# Message-Signalled Interrupt File

This block is one interrupt file: the unit that serves one privilege level of a hart. Devices raise an interrupt by writing its identity number to the single doorbell word at page offset 0 of the file's 4 KB page. The file keeps one pending bit and one enable bit per identity. From these it drives a level interrupt to the hart and reports the lowest-numbered identity that is both pending and enabled.

The hart never reads the arrays directly. It places a select address on an indirect port and then reads the 32-bit data word, or writes one. Pending words sit at select 0x80 upward and enable words at 0xC0 upward. A claim strobe from the hart clears the pending bit of the identity currently reported as top. Identity 0 is reserved and never stored.

Top module: `msi_intfile`

## Requirements
- R1: After reset all pending and enable bits are 0, `top_id_o` is 0 and `irq_o` is 0.
- R2: A doorbell write (`db_we_i` high, `db_addr_i` = 0) carrying a value n with 1 <= n < NUM_IDS sets pending bit n. The bit is visible from the next cycle as bit n%32 of the word read at select 0x80 + n/32.
- R3: A doorbell write of value 0, of any value >= NUM_IDS (all 32 bits compared), or to any offset other than 0 changes no state.
- R4: `top_id_o` is the smallest identity whose pending and enable bits are both 1, and 0 when there is none. It follows the stored arrays with no extra delay.
- R5: `irq_o` is 1 exactly when at least one identity is both pending and enabled.
- R6: `reg_rdata_o` follows `sel_i` combinationally. Select 0x80 + k returns pending bits 32k..32k+31, and select 0xC0 + k returns enable bits 32k..32k+31, with identity 32k+j in bit j.
- R7: An indirect write (`reg_we_i` high) to a mapped select replaces that whole word at the next edge. Bits for identity 0 and for identities >= NUM_IDS always read 0.
- R8: Unmapped select addresses read as 0, and writes to them change no state.
- R9: `claim_i` clears the pending bit of the identity shown on `top_id_o` in that cycle. The clear is applied after an indirect write to the same word. With `top_id_o` = 0 the claim has no effect.
- R10: When a doorbell set and a clear (an indirect write or a claim) target the same pending bit in one cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| db_we_i | input | 1 | Doorbell page write strobe |
| db_addr_i | input | 12 | Byte offset within the page |
| db_wdata_i | input | 32 | Written identity number |
| sel_i | input | 8 | Indirect select address |
| reg_we_i | input | 1 | Indirect data write strobe |
| reg_wdata_i | input | 32 | Indirect write data |
| reg_rdata_o | output | 32 | Indirect read data |
| claim_i | input | 1 | Clear the current top identity |
| top_id_o | output | 6 | Top pending-and-enabled identity, 0 if none |
| irq_o | output | 1 | Interrupt to the hart |

## Verification
A wrong pending or enable bit shows up at the ports in the cycle after the edge that stored it. It appears on the read word for its select, and also on `top_id_o` and `irq_o` whenever the bit is enabled or becomes the lowest active identity. The bench keeps its own model of both arrays and compares all three outputs on every cycle, so a bad bit is caught on the first cycle it is observable. Collision cycles (doorbell with a word write or a claim on the same bit) are driven on purpose, because a wrong ordering there leaves state that the arrays alone would hide until the next read.

// File: rtl/msi_if_pkg.sv
package msi_if_pkg;
  localparam int unsigned WORD_W        = 32;
  localparam int unsigned SEL_W         = 8;
  localparam int unsigned PAGE_AW       = 12;
  localparam logic [SEL_W-1:0] SEL_PEND_BASE = 8'h80;
  localparam logic [SEL_W-1:0] SEL_EN_BASE   = 8'hC0;
endpackage

// File: rtl/msi_db_decode.sv
module msi_db_decode
  import msi_if_pkg::*;
#(
  parameter int unsigned NUM_IDS = 64,
  parameter int unsigned ARR_W   = 64,
  localparam int unsigned IDX_W  = $clog2(ARR_W)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [PAGE_AW-1:0] addr_i,
  input  logic [WORD_W-1:0]  wdata_i,
  output logic [ARR_W-1:0]   set_o
);
  logic hit;
  assign hit = we_i && (addr_i == '0) && (wdata_i != '0) && (wdata_i < NUM_IDS);

  always_comb begin
    set_o = '0;
    if (hit) set_o[wdata_i[IDX_W-1:0]] = 1'b1;
  end

  assert_bad_db_ignored_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && (addr_i != '0 || wdata_i == '0 || wdata_i >= NUM_IDS)) |-> (set_o == '0));
endmodule

// File: rtl/msi_bit_array.sv
module msi_bit_array
  import msi_if_pkg::*;
#(
  parameter int unsigned NUM_IDS   = 64,
  parameter int unsigned NUM_WORDS = 2,
  localparam int unsigned ARR_W    = NUM_WORDS * WORD_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_WORDS-1:0] wr_en_i,
  input  logic [WORD_W-1:0]    wdata_i,
  input  logic [ARR_W-1:0]     clr_i,
  input  logic [ARR_W-1:0]     set_i,
  output logic [ARR_W-1:0]     bits_o
);
  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    for (genvar j = 0; j < WORD_W; j++) begin : g_bit
      localparam int unsigned IDX = w * WORD_W + j;
      if (IDX == 0 || IDX >= NUM_IDS) begin : g_none
        assign bits_o[IDX] = 1'b0;
      end else begin : g_flop
        logic q;
        logic d;
        // order: word write, then clear, then set (set wins)
        always_comb begin
          d = wr_en_i[w] ? wdata_i[j] : q;
          d = (d & ~clr_i[IDX]) | set_i[IDX];
        end
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) q <= 1'b0;
          else         q <= d;
        end
        assign bits_o[IDX] = q;
      end
    end
  end

  assert_set_wins_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i != '0) |=> ((bits_o & $past(set_i)) == $past(set_i)));
  assert_hold_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i == '0 && clr_i == '0 && set_i == '0) |=> $stable(bits_o));
endmodule

// File: rtl/msi_top_sel.sv
module msi_top_sel #(
  parameter int unsigned ARR_W = 64,
  localparam int unsigned IDX_W = $clog2(ARR_W)
) (
  input  logic [ARR_W-1:0] active_i,
  output logic [IDX_W-1:0] top_o
);
  // lowest index wins; scan downward so the last hit is the smallest
  always_comb begin
    top_o = '0;
    for (int i = ARR_W - 1; i >= 1; i--) begin
      if (active_i[i]) top_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/msi_reg_port.sv
module msi_reg_port
  import msi_if_pkg::*;
#(
  parameter int unsigned NUM_WORDS = 2,
  localparam int unsigned ARR_W    = NUM_WORDS * WORD_W
) (
  input  logic [SEL_W-1:0]     sel_i,
  input  logic                 we_i,
  input  logic [ARR_W-1:0]     pend_i,
  input  logic [ARR_W-1:0]     en_i,
  output logic [NUM_WORDS-1:0] pend_wr_o,
  output logic [NUM_WORDS-1:0] en_wr_o,
  output logic [WORD_W-1:0]    rdata_o
);
  always_comb begin
    pend_wr_o = '0;
    en_wr_o   = '0;
    rdata_o   = '0;
    for (int k = 0; k < NUM_WORDS; k++) begin
      if (sel_i == SEL_PEND_BASE + SEL_W'(k)) begin
        rdata_o      = pend_i[k*WORD_W +: WORD_W];
        pend_wr_o[k] = we_i;
      end
      if (sel_i == SEL_EN_BASE + SEL_W'(k)) begin
        rdata_o    = en_i[k*WORD_W +: WORD_W];
        en_wr_o[k] = we_i;
      end
    end
  end
endmodule

// File: rtl/msi_intfile.sv
module msi_intfile
  import msi_if_pkg::*;
#(
  parameter int unsigned NUM_IDS   = 64,
  localparam int unsigned NUM_WORDS = (NUM_IDS + WORD_W - 1) / WORD_W,
  localparam int unsigned ARR_W     = NUM_WORDS * WORD_W,
  localparam int unsigned IDX_W     = $clog2(ARR_W)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               db_we_i,
  input  logic [PAGE_AW-1:0] db_addr_i,
  input  logic [WORD_W-1:0]  db_wdata_i,
  input  logic [SEL_W-1:0]   sel_i,
  input  logic               reg_we_i,
  input  logic [WORD_W-1:0]  reg_wdata_i,
  output logic [WORD_W-1:0]  reg_rdata_o,
  input  logic               claim_i,
  output logic [IDX_W-1:0]   top_id_o,
  output logic               irq_o
);
  logic [ARR_W-1:0]     set_mask, clr_mask, pend_q, en_q, active;
  logic [NUM_WORDS-1:0] pend_wr, en_wr;

  msi_db_decode #(.NUM_IDS(NUM_IDS), .ARR_W(ARR_W)) i_db (
    .clk_i, .rst_ni, .we_i(db_we_i), .addr_i(db_addr_i), .wdata_i(db_wdata_i), .set_o(set_mask)
  );

  msi_reg_port #(.NUM_WORDS(NUM_WORDS)) i_port (
    .sel_i, .we_i(reg_we_i), .pend_i(pend_q), .en_i(en_q),
    .pend_wr_o(pend_wr), .en_wr_o(en_wr), .rdata_o(reg_rdata_o)
  );

  always_comb begin
    clr_mask = '0;
    if (claim_i && top_id_o != '0) clr_mask[top_id_o] = 1'b1;
  end

  msi_bit_array #(.NUM_IDS(NUM_IDS), .NUM_WORDS(NUM_WORDS)) i_pend (
    .clk_i, .rst_ni, .wr_en_i(pend_wr), .wdata_i(reg_wdata_i),
    .clr_i(clr_mask), .set_i(set_mask), .bits_o(pend_q)
  );

  msi_bit_array #(.NUM_IDS(NUM_IDS), .NUM_WORDS(NUM_WORDS)) i_en (
    .clk_i, .rst_ni, .wr_en_i(en_wr), .wdata_i(reg_wdata_i),
    .clr_i('0), .set_i('0), .bits_o(en_q)
  );

  assign active = pend_q & en_q;
  assign irq_o  = |active;

  msi_top_sel #(.ARR_W(ARR_W)) i_top (.active_i(active), .top_o(top_id_o));

  // checks against the selector and the port decode
  logic unmapped;
  always_comb begin
    unmapped = 1'b1;
    if (sel_i >= SEL_PEND_BASE && int'(sel_i) < int'(SEL_PEND_BASE) + int'(NUM_WORDS)) unmapped = 1'b0;
    if (sel_i >= SEL_EN_BASE && int'(sel_i) < int'(SEL_EN_BASE) + int'(NUM_WORDS))     unmapped = 1'b0;
  end

  assert_top_active_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (top_id_o != '0) |-> (pend_q[top_id_o] && en_q[top_id_o]));
  assert_top_lowest_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (top_id_o != '0) |-> ((active & ((ARR_W'(1) << top_id_o) - ARR_W'(1))) == '0));
  assert_irq_top_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (top_id_o != '0));
  assert_unmapped_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unmapped |-> (reg_rdata_o == '0));
  assert_unmapped_wr_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (unmapped && !db_we_i && !claim_i) |=> ($stable(pend_q) && $stable(en_q)));
  assert_claim_clears_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (claim_i && top_id_o != '0 && !set_mask[top_id_o]) |=> !pend_q[$past(top_id_o)]);
endmodule

// File: tb/test_msi_intfile.sv
module test_msi_intfile;
  localparam int CLK_PERIOD = 10;
  localparam int NUM = 64;
  localparam int NW = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic db_we = 1'b0, reg_we = 1'b0, claim = 1'b0;
  logic [11:0] db_addr = '0;
  logic [31:0] db_wdata = '0, reg_wdata = '0, rdata;
  logic [7:0] sel = '0;
  logic [5:0] top_id;
  logic irq;

  int total = 0, bad = 0;
  string tag = "R1";
  logic [NUM-1:0] m_pend = '0, m_en = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  msi_intfile i_msi_intfile (
    .clk_i(clk), .rst_ni(rst_n), .db_we_i(db_we), .db_addr_i(db_addr), .db_wdata_i(db_wdata),
    .sel_i(sel), .reg_we_i(reg_we), .reg_wdata_i(reg_wdata), .reg_rdata_o(rdata),
    .claim_i(claim), .top_id_o(top_id), .irq_o(irq)
  );

  function automatic int m_top();
    for (int i = 1; i < NUM; i++) if (m_pend[i] && m_en[i]) return i;
    return 0;
  endfunction

  function automatic logic [31:0] m_read(logic [7:0] s);
    for (int k = 0; k < NW; k++) begin
      if (s == 8'h80 + 8'(k)) return m_pend[k*32 +: 32];
      if (s == 8'hC0 + 8'(k)) return m_en[k*32 +: 32];
    end
    return 32'h0;
  endfunction

  task automatic compare();
    total++;
    if (int'(top_id) != m_top()) begin
      bad++; $display("FAIL %s/R4 top_id actual=%0d expected=%0d", tag, top_id, m_top());
    end
    total++;
    if (irq !== (m_top() != 0)) begin
      bad++; $display("FAIL %s/R5 irq actual=%0b expected=%0b", tag, irq, m_top() != 0);
    end
    total++;
    if (rdata !== m_read(sel)) begin
      bad++; $display("FAIL %s/R6 rdata sel=%h actual=%h expected=%h", tag, sel, rdata, m_read(sel));
    end
  endtask

  // drive one cycle at the negedge, compare, then advance model at the posedge
  task automatic cyc(input logic we, input logic [11:0] a, input logic [31:0] d,
                     input logic [7:0] s, input logic rwe, input logic [31:0] rwd, input logic clm);
    logic [NUM-1:0] np, ne;
    int t;
    db_we = we; db_addr = a; db_wdata = d; sel = s; reg_we = rwe; reg_wdata = rwd; claim = clm;
    #1;
    compare();
    np = m_pend; ne = m_en;
    t = m_top();
    for (int k = 0; k < NW; k++) begin
      if (rwe && s == 8'h80 + 8'(k)) np[k*32 +: 32] = rwd;
      if (rwe && s == 8'hC0 + 8'(k)) ne[k*32 +: 32] = rwd;
    end
    np[0] = 1'b0; ne[0] = 1'b0;
    if (clm && t != 0) np[t] = 1'b0;
    if (we && a == 12'h0 && d != 0 && d < NUM) np[d] = 1'b1;
    @(posedge clk);
    m_pend = np; m_en = ne;
    @(negedge clk);
  endtask

  task automatic rd(input logic [7:0] s);
    cyc(1'b0, 12'h0, 32'h0, s, 1'b0, 32'h0, 1'b0);
  endtask
  task automatic ring(input logic [11:0] a, input logic [31:0] d);
    cyc(1'b1, a, d, 8'h00, 1'b0, 32'h0, 1'b0);
  endtask
  task automatic wr(input logic [7:0] s, input logic [31:0] d);
    cyc(1'b0, 12'h0, 32'h0, s, 1'b1, d, 1'b0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    tag = "R1";
    #1; compare();
    rst_n = 1'b1;
    @(negedge clk);
    rd(8'h80); rd(8'h81); rd(8'hC0); rd(8'hC1);

    tag = "R2";
    ring(12'h0, 32'd5); ring(12'h0, 32'd40); ring(12'h0, 32'd63);
    rd(8'h80); rd(8'h81);

    tag = "R3";
    ring(12'h0, 32'd0); ring(12'h0, 32'd64); ring(12'h0, 32'h0010_0005);
    ring(12'h004, 32'd7); ring(12'hFFC, 32'd9);
    rd(8'h80); rd(8'h81);

    tag = "R7";
    wr(8'hC0, 32'hFFFF_FFFF); wr(8'hC1, 32'h8000_0000);
    rd(8'hC0); rd(8'hC1);

    tag = "R9";
    cyc(1'b0, 12'h0, 32'h0, 8'h80, 1'b0, 32'h0, 1'b1);
    cyc(1'b0, 12'h0, 32'h0, 8'h81, 1'b0, 32'h0, 1'b1);
    cyc(1'b0, 12'h0, 32'h0, 8'h81, 1'b0, 32'h0, 1'b1);
    rd(8'h81);

    tag = "R8";
    wr(8'h82, 32'hFFFF_FFFF); wr(8'h00, 32'hFFFF_FFFF);
    wr(8'hBF, 32'hFFFF_FFFF); wr(8'hC2, 32'hFFFF_FFFF); wr(8'hFF, 32'hFFFF_FFFF);
    rd(8'h82); rd(8'h80); rd(8'h81); rd(8'hC0); rd(8'hC1);

    tag = "R6";
    wr(8'h81, 32'hA5A5_0F0F); wr(8'h80, 32'h0000_0300);
    rd(8'h80); rd(8'h81);

    tag = "R10";
    cyc(1'b1, 12'h0, 32'd3, 8'h80, 1'b1, 32'h0, 1'b0);
    rd(8'h80);
    cyc(1'b1, 12'h0, 32'd3, 8'h80, 1'b0, 32'h0, 1'b1);
    rd(8'h80);
    cyc(1'b1, 12'h0, 32'd3, 8'h80, 1'b1, 32'h0, 1'b1);
    rd(8'h80);

    tag = "R4";
    for (int n = 0; n < 300; n++) begin
      logic [31:0] r;
      logic [7:0] s;
      r = $urandom;
      s = r[3] ? (8'h80 + 8'(r[4])) : (r[5] ? 8'hC0 + 8'(r[4]) : 8'(r[15:8]));
      cyc(r[0], r[1] ? 12'h0 : 12'(r[27:16]), r[2] ? 32'($urandom % 70) : $urandom,
          s, r[6] & r[7], $urandom, r[30]);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule